// File: doc/BRIEF.md
# Two-Pass Subranging Conversion Sequencer

This block is the digital sequencer and merge arithmetic for a 16-bit analog-to-digital conversion. The conversion uses one 9-bit coarse quantizer twice. A rising edge on the convert-start input puts the input track/hold into hold. After a short fixed aperture wait, the block asks the quantizer for a coarse code. It latches that code and drives it onto the upper 9 bits of a 16-bit DAC word. The lower 7 DAC bits are held at zero.

After the DAC and the residue amplifier have both settled, the block opens one residue-path switch and closes the other. It then places the residue track/hold in hold and asks the quantizer for a fine code. The two codes overlap by 2 bits. The merge stage removes the deliberate half-range residue offset and absorbs coarse-pass error. It clamps the sum to 16 bits and presents the result with a one-cycle done pulse.

The analog parts sit outside the block. Each one is represented only by a control pin, a fixed settle count, or a start/valid handshake with the quantizer model.

Top module: `subrange_seq`

## Requirements
- R1: While reset is applied, and right after it is released, busy, done, both hold controls, the quantizer start and the path-B switch control are low, and the path-A switch control is high. The DAC word and the result are zero.
- R2: A rising edge on `conv_start_i` sampled while idle sets `in_hold_o` and `busy_o` at the next clock edge.
- R3: The first quantizer start is a one-cycle pulse. It rises exactly `APERTURE_CYC` cycles after `in_hold_o` rises.
- R4: A code accepted with `q_valid_i` after the first start appears on `dac_word_o[15:7]` at the edge that accepts it. `dac_word_o[6:0]` is always zero.
- R5: `sw3_on_o` rises and `sw2_on_o` falls together, exactly max(`DAC_SETTLE_CYC`, `RES_SETTLE_CYC`) cycles after the coarse code is accepted. The two switch controls are always complementary.
- R6: `res_hold_o` rises one cycle after `sw3_on_o` rises. The second quantizer start pulse rises one cycle after `res_hold_o` rises.
- R7: At the edge that accepts the fine code, both hold controls return low, `sw2_on_o` returns high and `sw3_on_o` returns low.
- R8: One cycle after the fine code is accepted, `done_o` pulses high for one cycle. `result_o` then equals (coarse·128 + fine − 128), clamped to 0…65535. `result_o` does not change at any other time.
- R9: `busy_o` stays high from the R2 edge until the edge that raises `done_o`, and it falls at that same edge.
- R10: Convert-start edges that arrive while busy start nothing. A start level that is still high after done does not retrigger. Each conversion issues exactly two quantizer start pulses.
- R11: `q_valid_i` asserted while idle has no effect: the DAC word and the result keep their values and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_start_i | input | 1 | Convert start; a rising edge begins a conversion |
| q_valid_i | input | 1 | Quantizer code valid |
| q_code_i | input | CODE_W | Quantizer code |
| q_start_o | output | 1 | Quantizer sample strobe, one-cycle pulse |
| in_hold_o | output | 1 | Input track/hold: 1 = hold |
| res_hold_o | output | 1 | Residue track/hold: 1 = hold |
| sw2_on_o | output | 1 | Residue path-A switch: 1 = closed |
| sw3_on_o | output | 1 | Residue path-B switch: 1 = closed |
| dac_word_o | output | OUT_W | DAC word; coarse code in the upper bits |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse with a new result |
| result_o | output | OUT_W | Merged and clamped result |

## Verification
The bench builds the block with `APERTURE_CYC`=3, `DAC_SETTLE_CYC`=4 and `RES_SETTLE_CYC`=7. With these values the residue settle count is the longer one, so the wait before the switch change tests that the block takes the maximum of the two counts and not their sum or the DAC count. Randomized quantizer latencies of 1 to 4 cycles exercise the handshake at each pass. Directed code pairs reach both clamps and the points just inside them, and the offset boundary at fine = 128. Extra start edges are injected during the settle wait.

// File: rtl/sub_pkg.sv
package sub_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_APERT,
    ST_Q1_REQ,
    ST_Q1_WAIT,
    ST_SETTLE,
    ST_SWITCH,
    ST_RHOLD,
    ST_Q2_REQ,
    ST_Q2_WAIT,
    ST_MERGE
  } seq_state_e;

  typedef struct packed {
    logic in_hold;
    logic res_hold;
    logic sw2_on;
    logic sw3_on;
    logic q_start;
  } ctl_t;

  function automatic ctl_t decode_ctl(seq_state_e s);
    ctl_t c;
    c.in_hold  = s inside {ST_APERT, ST_Q1_REQ, ST_Q1_WAIT, ST_SETTLE,
                           ST_SWITCH, ST_RHOLD, ST_Q2_REQ, ST_Q2_WAIT};
    c.sw3_on   = s inside {ST_SWITCH, ST_RHOLD, ST_Q2_REQ, ST_Q2_WAIT};
    c.sw2_on   = !c.sw3_on;
    c.res_hold = s inside {ST_RHOLD, ST_Q2_REQ, ST_Q2_WAIT};
    c.q_start  = s inside {ST_Q1_REQ, ST_Q2_REQ};
    return c;
  endfunction

endpackage

// File: rtl/sub_edge.sv
module sub_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/sub_timer.sv
// Saturating run-length counter: hit_o is high from the LEN-th running cycle on.
module sub_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic hit_o
);
  localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sub_merge.sv
// Combine coarse and fine codes, remove the residue offset, clamp to OUT_W bits.
module sub_merge #(
  parameter int unsigned CODE_W = 9,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned OFFSET = 128
) (
  input  logic [CODE_W-1:0] coarse_i,
  input  logic [CODE_W-1:0] fine_i,
  output logic [OUT_W-1:0]  res_o
);
  localparam int unsigned SH = OUT_W - CODE_W;
  localparam int unsigned SW = OUT_W + 2;

  logic [OUT_W-1:0] coarse_ext;
  logic [SW-1:0]    sum;

  assign coarse_ext = {coarse_i, {SH{1'b0}}};
  assign sum = SW'(coarse_ext) + SW'(fine_i) - SW'(OFFSET);

  always_comb begin
    if (sum[SW-1])      res_o = '0;  // below zero
    else if (sum[SW-2]) res_o = '1;  // above full scale
    else                res_o = sum[OUT_W-1:0];
  end
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
  import sub_pkg::*;
#(
  parameter int unsigned CODE_W         = 9,
  parameter int unsigned OUT_W          = 16,
  parameter int unsigned APERTURE_CYC   = 3,
  parameter int unsigned DAC_SETTLE_CYC = 12,
  parameter int unsigned RES_SETTLE_CYC = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              q_valid_i,
  input  logic [CODE_W-1:0] q_code_i,
  output logic              q_start_o,
  output logic              in_hold_o,
  output logic              res_hold_o,
  output logic              sw2_on_o,
  output logic              sw3_on_o,
  output logic [OUT_W-1:0]  dac_word_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [OUT_W-1:0]  result_o
);
  localparam int unsigned SH     = OUT_W - CODE_W;
  localparam int unsigned OFFSET = 1 << SH;
  localparam int unsigned N_SET  = 2;

  seq_state_e state_q, state_d;
  ctl_t       ctl_q;

  logic              start_rise;
  logic              ap_hit;
  logic [N_SET-1:0]  set_hit;
  logic [CODE_W-1:0] coarse_q, fine_q;
  logic [OUT_W-1:0]  dac_q, result_q, merged;
  logic              busy_q, done_q;
  logic              take_coarse, take_fine;

  sub_edge i_start_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (conv_start_i),
    .rise_o (start_rise)
  );

  sub_timer #(.LEN(APERTURE_CYC)) i_ap_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_APERT),
    .hit_o  (ap_hit)
  );

  // Index 0: DAC settle, index 1: residue amplifier settle; both run in parallel.
  for (genvar g = 0; g < N_SET; g++) begin : g_settle
    localparam int unsigned L = (g == 0) ? DAC_SETTLE_CYC : RES_SETTLE_CYC;
    sub_timer #(.LEN(L)) i_set_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (state_q == ST_SETTLE),
      .hit_o  (set_hit[g])
    );
  end

  sub_merge #(
    .CODE_W (CODE_W),
    .OUT_W  (OUT_W),
    .OFFSET (OFFSET)
  ) i_merge (
    .coarse_i (coarse_q),
    .fine_i   (fine_q),
    .res_o    (merged)
  );

  assign take_coarse = (state_q == ST_Q1_WAIT) && q_valid_i;
  assign take_fine   = (state_q == ST_Q2_WAIT) && q_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_rise)  state_d = ST_APERT;
      ST_APERT:   if (ap_hit)      state_d = ST_Q1_REQ;
      ST_Q1_REQ:                   state_d = ST_Q1_WAIT;
      ST_Q1_WAIT: if (take_coarse) state_d = ST_SETTLE;
      ST_SETTLE:  if (&set_hit)    state_d = ST_SWITCH;
      ST_SWITCH:                   state_d = ST_RHOLD;
      ST_RHOLD:                    state_d = ST_Q2_REQ;
      ST_Q2_REQ:                   state_d = ST_Q2_WAIT;
      ST_Q2_WAIT: if (take_fine)   state_d = ST_MERGE;
      ST_MERGE:                    state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctl_q   <= decode_ctl(ST_IDLE);
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ctl_q   <= decode_ctl(state_d);
      busy_q  <= (state_d != ST_IDLE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q <= '0;
      fine_q   <= '0;
      dac_q    <= '0;
    end else begin
      if (take_coarse) begin
        coarse_q <= q_code_i;
        dac_q    <= {q_code_i, {SH{1'b0}}};
      end
      if (take_fine) fine_q <= q_code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (state_q == ST_MERGE);
      if (state_q == ST_MERGE) result_q <= merged;
    end
  end

  assign q_start_o  = ctl_q.q_start;
  assign in_hold_o  = ctl_q.in_hold;
  assign res_hold_o = ctl_q.res_hold;
  assign sw2_on_o   = ctl_q.sw2_on;
  assign sw3_on_o   = ctl_q.sw3_on;
  assign dac_word_o = dac_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign result_o   = result_q;

endmodule

// File: rtl/sub_seq_chk.sv
module sub_seq_chk #(
  parameter int unsigned CODE_W = 9,
  parameter int unsigned OUT_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             conv_start_i,
  input logic             q_start_o,
  input logic             in_hold_o,
  input logic             res_hold_o,
  input logic             sw2_on_o,
  input logic             sw3_on_o,
  input logic [OUT_W-1:0] dac_word_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [OUT_W-1:0] result_o
);
  localparam int unsigned SH = OUT_W - CODE_W;

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_i && !$past(conv_start_i) && !busy_o) |=> (busy_o && in_hold_o));

  p_qstart_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_start_o |=> !q_start_o);

  p_dac_low_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_word_o[SH-1:0] == '0);

  p_sw_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw2_on_o != sw3_on_o);

  p_hold_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hold_o |-> (sw3_on_o && in_hold_o));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_hold_o) |-> (!res_hold_o && sw2_on_o && !sw3_on_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  p_busy_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_idle_dac_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(dac_word_o));

endmodule

bind subrange_seq sub_seq_chk #(
  .CODE_W (CODE_W),
  .OUT_W  (OUT_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_start_i (conv_start_i),
  .q_start_o    (q_start_o),
  .in_hold_o    (in_hold_o),
  .res_hold_o   (res_hold_o),
  .sw2_on_o     (sw2_on_o),
  .sw3_on_o     (sw3_on_o),
  .dac_word_o   (dac_word_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .result_o     (result_o)
);

// File: tb/test_subrange_seq.sv
`timescale 1ns/1ps
module test_subrange_seq;
  localparam int CW = 9;
  localparam int OW = 16;
  localparam int AP = 3;
  localparam int DS = 4;
  localparam int RS = 7;
  localparam int MS = (DS > RS) ? DS : RS;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          conv_start_i = 1'b0;
  logic          q_valid_i = 1'b0;
  logic [CW-1:0] q_code_i = '0;
  logic          q_start_o, in_hold_o, res_hold_o, sw2_on_o, sw3_on_o;
  logic [OW-1:0] dac_word_o, result_o;
  logic          busy_o, done_o;

  subrange_seq #(
    .CODE_W(CW), .OUT_W(OW), .APERTURE_CYC(AP),
    .DAC_SETTLE_CYC(DS), .RES_SETTLE_CYC(RS)
  ) i_subrange_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_start_i(conv_start_i),
    .q_valid_i(q_valid_i), .q_code_i(q_code_i), .q_start_o(q_start_o),
    .in_hold_o(in_hold_o), .res_hold_o(res_hold_o), .sw2_on_o(sw2_on_o),
    .sw3_on_o(sw3_on_o), .dac_word_o(dac_word_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o)
  );

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  // event monitor: cycle stamps of output edges, sampled at negedge
  int t_hold, t_qs1, t_qs2, t_sw3, t_rh, t_rel, t_done, t_bfall, qs_cnt;
  logic p_hold = 0, p_qs = 0, p_sw3 = 0, p_rh = 0, p_done = 0, p_busy = 0;
  always @(negedge clk_i) begin
    if (in_hold_o && !p_hold) t_hold = cyc;
    if (!in_hold_o && p_hold) t_rel = cyc;
    if (q_start_o && !p_qs) begin
      qs_cnt++;
      if (qs_cnt == 1) t_qs1 = cyc; else t_qs2 = cyc;
    end
    if (sw3_on_o && !p_sw3) t_sw3 = cyc;
    if (res_hold_o && !p_rh) t_rh = cyc;
    if (done_o && !p_done) t_done = cyc;
    if (!busy_o && p_busy) t_bfall = cyc;
    p_hold = in_hold_o; p_qs = q_start_o; p_sw3 = sw3_on_o;
    p_rh = res_hold_o; p_done = done_o; p_busy = busy_o;
  end

  function automatic int exp_res(input int c, input int f);
    int v;
    v = c * 128 + f - 128;
    if (v < 0) v = 0;
    if (v > 65535) v = 65535;
    return v;
  endfunction

  task automatic wait_qs();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (q_start_o) return;
    end
  endtask

  task automatic run_conv(input int c, input int f, input int l1, input int l2,
                          input bit poke, input bit noise);
    int c0, cv1, cv2, old_dac, old_res;
    @(negedge clk_i);
    if (noise) begin
      old_dac = int'(dac_word_o);
      old_res = int'(result_o);
      q_valid_i = 1'b1;
      q_code_i  = CW'($urandom);
      @(negedge clk_i);
      q_valid_i = 1'b0;
      @(negedge clk_i);
      chk(int'(dac_word_o) == old_dac, "R11 dac", int'(dac_word_o), old_dac);
      chk(int'(result_o) == old_res, "R11 result", int'(result_o), old_res);
      chk(!busy_o, "R11 busy", int'(busy_o), 0);
    end
    qs_cnt = 0;
    conv_start_i = 1'b1;
    c0 = cyc;
    @(negedge clk_i);
    conv_start_i = 1'b0;
    chk(busy_o && in_hold_o, "R2 busy/hold", int'({busy_o, in_hold_o}), 3);
    wait_qs();
    repeat (l1) @(negedge clk_i);
    q_valid_i = 1'b1;
    q_code_i  = CW'(c);
    cv1 = cyc;
    @(negedge clk_i);
    q_valid_i = 1'b0;
    q_code_i  = CW'($urandom);
    chk(int'(dac_word_o[15:7]) == c, "R4 dac high", int'(dac_word_o[15:7]), c);
    chk(dac_word_o[6:0] == 7'd0, "R4 dac low", int'(dac_word_o[6:0]), 0);
    if (poke) conv_start_i = 1'b1;  // edge while busy, left high past done
    wait_qs();
    repeat (l2) @(negedge clk_i);
    q_valid_i = 1'b1;
    q_code_i  = CW'(f);
    cv2 = cyc;
    @(negedge clk_i);
    q_valid_i = 1'b0;
    chk(!in_hold_o && !res_hold_o && sw2_on_o && !sw3_on_o, "R7 release",
        int'({in_hold_o, res_hold_o, sw2_on_o, sw3_on_o}), 2);
    chk(busy_o && !done_o, "R9 busy before done", int'({busy_o, done_o}), 2);
    @(negedge clk_i);
    chk(done_o && !busy_o, "R9 done/busy", int'({done_o, busy_o}), 2);
    chk(int'(result_o) == exp_res(c, f), "R8 result", int'(result_o), exp_res(c, f));
    @(negedge clk_i);
    chk(!done_o, "R8 done pulse", int'(done_o), 0);
    chk(t_hold == c0 + 1, "R2 hold time", t_hold, c0 + 1);
    chk(t_qs1 - t_hold == AP, "R3 aperture", t_qs1 - t_hold, AP);
    chk(t_sw3 == cv1 + 1 + MS, "R5 settle", t_sw3, cv1 + 1 + MS);
    chk(t_rh == t_sw3 + 1, "R6 res hold", t_rh, t_sw3 + 1);
    chk(t_qs2 == t_rh + 1, "R6 second start", t_qs2, t_rh + 1);
    chk(t_rel == cv2 + 1, "R7 release time", t_rel, cv2 + 1);
    chk(t_done == cv2 + 2 && t_bfall == t_done, "R9 busy fall", t_bfall, cv2 + 2);
    repeat (4) @(negedge clk_i);
    chk(qs_cnt == 2, "R10 start count", qs_cnt, 2);
    chk(!busy_o, "R10 no retrigger", int'(busy_o), 0);
    conv_start_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 200000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !in_hold_o && !res_hold_o && !q_start_o,
        "R1 idle in reset", int'({busy_o, done_o, in_hold_o, res_hold_o, q_start_o}), 0);
    chk(sw2_on_o && !sw3_on_o, "R1 switches", int'({sw2_on_o, sw3_on_o}), 2);
    chk(dac_word_o == '0 && result_o == '0, "R1 data", int'(result_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && sw2_on_o && !sw3_on_o, "R1 after release",
        int'({busy_o, sw2_on_o, sw3_on_o}), 2);

    // directed corners around offset and clamps
    run_conv(0,   0,   1, 1, 0, 1);
    run_conv(0,   127, 2, 1, 0, 0);
    run_conv(0,   128, 1, 3, 0, 0);
    run_conv(0,   200, 4, 2, 1, 0);
    run_conv(511, 0,   1, 1, 0, 1);
    run_conv(511, 255, 3, 4, 0, 0);
    run_conv(511, 256, 1, 2, 1, 0);
    run_conv(511, 511, 2, 2, 0, 0);
    run_conv(256, 128, 1, 1, 0, 0);

    for (int k = 0; k < 40; k++) begin
      run_conv(int'($urandom % 512), int'($urandom % 512),
               1 + int'($urandom % 4), 1 + int'($urandom % 4),
               bit'($urandom % 2), bit'($urandom % 2));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule